// File: doc/BRIEF.md
# Decision-Driven Receiver Offset Trim Loop

This block trims the DC offset of a high-gain receive front end by watching the decisions taken on the edge (crossing) samples of a bang-bang phase detector. When there is no offset, samples taken at the data crossing split evenly between one and zero. A residual offset in the amplifier chain, or in the sampling latch itself, tilts that split. Because the latches are part of the measured path, their offset is trimmed together with the amplifier's. No analog averaging, long RC time constant or balanced data pattern is needed.

Each strobed decision pushes a signed running sum up by one for a one and down by one for a zero. This sum is the digital low-pass filter. When its magnitude passes a power-of-two threshold, the 6-bit two's-complement trim code moves one step against the tilt and the sum restarts from zero. The code drives a current-steering DAC at the input stage, which lies outside this block. A one-cycle strobe marks every change of the code.

Top module: `ofc_loop`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the trim code is 0, the update strobe is low and the running sum is 0.
- R2: A cycle with `dec_valid` low changes neither the running sum nor the trim code, whatever `dec_bit` holds, and the strobe stays low in the cycle after it.
- R3: The running sum (17-bit signed) takes a step only when a decision exceeds the threshold of 2^THR_LOG2 in magnitude, and it clears to 0 in that same step. A sum that only reaches exactly ±2^THR_LOG2 causes no step.
- R4: A step caused by excess ones (`dec_bit`=1 counts +1) lowers the trim code by one. A step caused by excess zeros (`dec_bit`=0 counts -1) raises it by one.
- R5: The trim code is two's complement, limited to -32..+31. A step that would leave this range leaves the code unchanged and raises no strobe, but the running sum still clears.
- R6: `corr_upd` is high for exactly the cycles in which `corr_code` holds a new value, and low otherwise.
- R7: The trim code and the strobe take their new values on the same rising edge that accepts the decision which crosses the threshold.
- R8: A stream of decisions balanced between ones and zeros, such as alternating values, never moves the trim code.
- R9: The trim code never changes by more than one LSB from one cycle to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Loop clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | High when `dec_bit` carries a new crossing-sample decision |
| dec_bit | input | 1 | Crossing-sample decision: 1 counts +1, 0 counts -1 |
| corr_code | output | CODE_W (6) | Signed trim code for the input-stage current DAC |
| corr_upd | output | 1 | One-cycle pulse when `corr_code` changes |

## Verification
The bound checker watches several properties on every cycle. The running sum stays inside the threshold window. Every threshold trip clears the sum. A trip moves the code by one in the correct direction, or holds it at a limit. The strobe matches a code change exactly. Idle cycles move nothing. The number of decisions needed to trip, the exact-threshold boundary, the clearing of the sum at a saturated limit and the effect of a balanced stream depend on long input histories. Only the bench's scenarios show these, checked against its cycle-by-cycle reference model.

// File: rtl/ofc_pkg.sv
package ofc_pkg;

  // Signed contribution of one crossing-sample decision.
  function automatic int vote_term(input logic one);
    return one ? 1 : -1;
  endfunction

  // Trim code after a trip request, clamped to [lo, hi].
  function automatic int sat_step(input int cur, input logic dn, input logic up,
                                  input int lo, input int hi);
    int nxt;
    nxt = cur;
    if (dn && cur > lo) nxt = cur - 1;
    else if (up && cur < hi) nxt = cur + 1;
    return nxt;
  endfunction

endpackage

// File: rtl/ofc_vote.sv
module ofc_vote #(
  parameter int ACC_W = 17
) (
  input  logic                    dec_valid,
  input  logic                    dec_bit,
  output logic                    term_en,
  output logic signed [ACC_W-1:0] term
);
  import ofc_pkg::*;

  assign term_en = dec_valid;
  assign term    = ACC_W'(vote_term(dec_bit));

endmodule

// File: rtl/ofc_integrator.sv
module ofc_integrator #(
  parameter int ACC_W    = 17,
  parameter int THR_LOG2 = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    term_en,
  input  logic signed [ACC_W-1:0] term,
  output logic signed [ACC_W-1:0] acc_q,
  output logic                    trip_hi,
  output logic                    trip_lo
);
  localparam int                    THR_I   = 1 << THR_LOG2;
  localparam logic signed [ACC_W-1:0] POS_LIM = ACC_W'(THR_I);
  localparam logic signed [ACC_W-1:0] NEG_LIM = -POS_LIM;

  logic signed [ACC_W-1:0] acc_sum;

  assign acc_sum = acc_q + term;
  assign trip_hi = term_en && (acc_sum > POS_LIM);
  assign trip_lo = term_en && (acc_sum < NEG_LIM);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (term_en) begin
      if (trip_hi || trip_lo) acc_q <= '0;
      else                    acc_q <= acc_sum;
    end
  end

endmodule

// File: rtl/ofc_code_reg.sv
module ofc_code_reg #(
  parameter int CODE_W = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     trip_hi,
  input  logic                     trip_lo,
  output logic signed [CODE_W-1:0] code_q,
  output logic                     upd_q
);
  import ofc_pkg::*;

  localparam int CODE_MAX = (1 << (CODE_W - 1)) - 1;
  localparam int CODE_MIN = -(1 << (CODE_W - 1));

  logic signed [CODE_W-1:0] code_d;
  logic                     upd_d;

  assign code_d = CODE_W'(sat_step(int'(code_q), trip_hi, trip_lo, CODE_MIN, CODE_MAX));
  assign upd_d  = (code_d != code_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q <= '0;
      upd_q  <= 1'b0;
    end else begin
      code_q <= code_d;
      upd_q  <= upd_d;
    end
  end

endmodule

// File: rtl/ofc_loop.sv
module ofc_loop #(
  parameter int ACC_W    = 17,
  parameter int THR_LOG2 = 12,
  parameter int CODE_W   = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     dec_valid,
  input  logic                     dec_bit,
  output logic signed [CODE_W-1:0] corr_code,
  output logic                     corr_upd
);

  logic                    term_en;
  logic signed [ACC_W-1:0] term;
  logic signed [ACC_W-1:0] acc_q;
  logic                    trip_hi;
  logic                    trip_lo;

  ofc_vote #(.ACC_W(ACC_W)) u_vote (
    .dec_valid (dec_valid),
    .dec_bit   (dec_bit),
    .term_en   (term_en),
    .term      (term)
  );

  ofc_integrator #(.ACC_W(ACC_W), .THR_LOG2(THR_LOG2)) u_integ (
    .clk     (clk),
    .rst_n   (rst_n),
    .term_en (term_en),
    .term    (term),
    .acc_q   (acc_q),
    .trip_hi (trip_hi),
    .trip_lo (trip_lo)
  );

  ofc_code_reg #(.CODE_W(CODE_W)) u_code (
    .clk     (clk),
    .rst_n   (rst_n),
    .trip_hi (trip_hi),
    .trip_lo (trip_lo),
    .code_q  (corr_code),
    .upd_q   (corr_upd)
  );

endmodule

// File: rtl/ofc_loop_chk.sv
module ofc_loop_chk #(
  parameter int ACC_W    = 17,
  parameter int THR_LOG2 = 12,
  parameter int CODE_W   = 6
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     dec_valid,
  input logic signed [CODE_W-1:0] corr_code,
  input logic                     corr_upd,
  input logic                     trip_hi,
  input logic                     trip_lo,
  input logic signed [ACC_W-1:0]  acc_q
);
  localparam logic signed [ACC_W-1:0]  POS_LIM = ACC_W'(1 << THR_LOG2);
  localparam logic signed [ACC_W-1:0]  NEG_LIM = -POS_LIM;
  localparam logic signed [CODE_W-1:0] C_MAX   = CODE_W'((1 << (CODE_W - 1)) - 1);
  localparam logic signed [CODE_W-1:0] C_MIN   = -C_MAX - CODE_W'(1);

  p_acc_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q <= POS_LIM) && (acc_q >= NEG_LIM));

  p_trip_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_hi || trip_lo) |=> (acc_q == '0));

  p_single_dir_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(trip_hi && trip_lo));

  p_step_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_hi && corr_code != C_MIN) |=> ((corr_code + CODE_W'(1)) == $past(corr_code)));

  p_step_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_lo && corr_code != C_MAX) |=> (corr_code == ($past(corr_code) + CODE_W'(1))));

  p_hold_min_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_hi && corr_code == C_MIN) |=> (corr_code == C_MIN && !corr_upd));

  p_hold_max_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_lo && corr_code == C_MAX) |=> (corr_code == C_MAX && !corr_upd));

  p_strobe_new_r6: assert property (@(posedge clk) disable iff (!rst_n)
    corr_upd |-> (corr_code != $past(corr_code)));

  p_strobe_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !corr_upd |-> $stable(corr_code));

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |=> ($stable(corr_code) && !corr_upd));

  p_one_lsb_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((corr_code - $past(corr_code)) == CODE_W'(0)) ||
    ((corr_code - $past(corr_code)) == CODE_W'(1)) ||
    (($past(corr_code) - corr_code) == CODE_W'(1)));

endmodule

bind ofc_loop ofc_loop_chk #(.ACC_W(ACC_W), .THR_LOG2(THR_LOG2), .CODE_W(CODE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dec_valid (dec_valid),
  .corr_code (corr_code),
  .corr_upd  (corr_upd),
  .trip_hi   (trip_hi),
  .trip_lo   (trip_lo),
  .acc_q     (acc_q)
);

// File: tb/test_ofc_loop.sv
`timescale 1ns/1ps
module test_ofc_loop;
  localparam int TL   = 4;
  localparam int THR  = 1 << TL;
  localparam int TRIP = THR + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dec_valid = 1'b0;
  logic dec_bit = 1'b0;
  logic signed [5:0] corr_code;
  logic corr_upd;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  // Reference model state
  int m_acc = 0;
  int m_code = 0;
  int m_upd = 0;

  always #2 clk = ~clk;

  ofc_loop #(.ACC_W(17), .THR_LOG2(TL), .CODE_W(6)) i_ofc_loop (
    .clk       (clk),
    .rst_n     (rst_n),
    .dec_valid (dec_valid),
    .dec_bit   (dec_bit),
    .corr_code (corr_code),
    .corr_upd  (corr_upd)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // Behavioural model: a queue of pending decisions is not needed; the
  // model applies each accepted decision as soon as it is sampled.
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_acc = 0; m_code = 0; m_upd = 0;
    end else begin
      m_upd = 0;
      if (dec_valid) begin
        int s;
        s = m_acc + (dec_bit ? 1 : -1);
        if (s > THR || s < -THR) begin
          m_acc = 0;
          if (s > THR && m_code > -32) begin m_code = m_code - 1; m_upd = 1; end
          if (s < -THR && m_code < 31) begin m_code = m_code + 1; m_upd = 1; end
        end else begin
          m_acc = s;
        end
      end
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R4 per-cycle code", int'(corr_code), m_code);
      check("R6 per-cycle strobe", int'(corr_upd), m_upd);
    end
  end

  task automatic send(input logic b, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      dec_valid = 1'b1;
      dec_bit = b;
    end
    @(negedge clk);
    dec_valid = 1'b0;
  endtask

  task automatic idle_noise(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      dec_valid = 1'b0;
      dec_bit = ~dec_bit;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check("R1 reset code", int'(corr_code), 0);
    check("R1 reset strobe", int'(corr_upd), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 code after release", int'(corr_code), 0);

    send(1'b1, THR);
    check("R3 exact threshold gives no step", int'(corr_code), 0);
    send(1'b1, 1);
    check("R7 code on crossing edge", int'(corr_code), -1);
    check("R7 strobe on crossing edge", int'(corr_upd), 1);
    @(negedge clk);
    check("R6 strobe lasts one cycle", int'(corr_upd), 0);

    idle_noise(20);
    check("R2 invalid decisions ignored", int'(corr_code), -1);
    check("R2 strobe low while idle", int'(corr_upd), 0);

    send(1'b1, THR);
    check("R3 sum cleared after step", int'(corr_code), -1);
    send(1'b1, 1);
    check("R4 excess ones lower code", int'(corr_code), -2);

    for (int i = 0; i < 100; i++) begin
      send(1'b0, 1);
      send(1'b1, 1);
    end
    check("R8 balanced stream holds code", int'(corr_code), -2);

    send(1'b0, TRIP);
    check("R4 excess zeros raise code", int'(corr_code), -1);

    for (int i = 0; i < 32; i++) send(1'b0, TRIP);
    check("R5 reach upper limit", int'(corr_code), 31);
    send(1'b0, TRIP);
    check("R5 saturated high", int'(corr_code), 31);
    check("R5 no strobe at limit", int'(corr_upd), 0);
    send(1'b1, TRIP);
    check("R5 sum cleared at upper limit", int'(corr_code), 30);

    for (int i = 0; i < 62; i++) send(1'b1, TRIP);
    check("R5 reach lower limit", int'(corr_code), -32);
    send(1'b1, TRIP);
    check("R5 saturated low", int'(corr_code), -32);
    check("R9 no wrap at lower limit", int'(corr_upd), 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL R7 watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule